// File: doc/BRIEF.md
# TPM SPI Register Access Engine

This block is an SPI master that carries out one register access to a discrete TPM. The host gives a 16-bit register address, a direction flag and a byte count, then pulses `start`. The engine selects the device and sends a four-byte header. It then waits for the device to signal that it is ready, moves the data bytes, and releases chip select. It closes with a one-cycle `done` pulse that carries a status code.

Write data is taken from the host one byte at a time. `wr_take` is high in the cycle in which `wr_data` is latched, and the host advances to the next byte after that edge. Each read byte is presented on `rd_data` with a one-cycle `rd_valid` strobe. The serial clock comes from the system clock through a parameterised divider.

If the device holds off the transfer, the engine keeps chip select low and sends filler bytes. It samples the device's ready flag in each returned byte. After a bounded number of filler bytes it gives up and reports a timeout.

Top module: `tpm_spi_xact`

## Requirements
- R1: Header byte 0 carries the direction in bit 7 (1 = read, 0 = write) and the byte count minus one in bits 6:0.
- R2: A byte count of 0 or above 128 is refused. `done` pulses on the cycle after `start`, with status 1. Chip select and SCLK show no activity.
- R3: Header byte 1 is always 0xD4.
- R4: Header bytes 2 and 3 are the register address, high byte first, then low byte.
- R5: If bit 0 of the byte received during header byte 3 is 1, the data bytes follow directly, with no filler byte.
- R6: Otherwise the engine sends 0x00 filler bytes and proceeds once bit 0 of a received byte is 1. The other bits of a received byte have no effect.
- R7: If 50 filler bytes pass without bit 0 set, the access ends with status 2 and no data byte is sent.
- R8: A write sends exactly the requested number of bytes. Each byte is taken from `wr_data` in a cycle with `wr_take` high.
- R9: A read returns exactly the requested number of bytes. Each is shifted in from MISO and given once on `rd_data` with `rd_valid`.
- R10: `cs_n` falls once per accepted access and stays low through header, filler and data. It is high again by the `done` cycle, whatever the outcome.
- R11: SPI mode 0, MSB first. SCLK is low whenever `cs_n` is high, and each SCLK half period lasts CLK_DIV system cycles.
- R12: `done` is a single-cycle pulse. `status` is valid with it: 0 success, 1 invalid parameter, 2 timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an access (ignored while busy) |
| is_read | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | TPM register address |
| len | input | LEN_W | Byte count |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| status | output | 2 | Result code, valid with done |
| wr_take | output | 1 | Write byte latched this cycle |
| wr_data | input | 8 | Next write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to device |
| miso | input | 1 | SPI data from device |

## Verification
A device model on the bus logs every MOSI byte and answers with a chosen number of not-ready bytes (0xFE) before a ready byte.

- Zero hold-off separates the direct path from the polled path.
- A hold-off of 3 tests polling whose not-ready answers have every bit but bit 0 set.
- Hold-offs of 50 and 51 fall on either side of the timeout.

Writes of 4 bytes and reads of 1, 2 and 128 bytes show whether the count encoding and data movement are exact at both ends of the legal range. Counts of 0, 129 and 255 must leave the bus untouched.

// File: rtl/tpm_spi_xact.sv
module tpm_spi_xact #(
  parameter int CLK_DIV    = 2,
  parameter int POLL_LIMIT = 50,
  parameter int MAX_LEN    = 128,
  parameter int LEN_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_read,
  input  logic [15:0]      addr,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status,
  output logic             wr_take,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam int PC_W  = $clog2(POLL_LIMIT + 1);
  localparam logic [1:0] ST_OK = 2'd0, ST_BADPARAM = 2'd1, ST_TIMEOUT = 2'd2;
  localparam logic [7:0] SEL_BYTE = 8'hD4;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_BIT} st_t;
  typedef enum logic [1:0] {P_HDR, P_WAIT, P_DATA} ph_t;

  st_t              state;
  ph_t              phase;
  logic [15:0]      a_q;
  logic             rd_q;
  logic [LEN_W-1:0] len_q, idx;
  logic [PC_W-1:0]  poll;
  logic [DIV_W-1:0] div;
  logic [2:0]       bit_cnt;
  logic [7:0]       tx_sr, rx_sr, next_byte;
  logic             tick, bad_len;

  assign busy    = (state != S_IDLE);
  assign tick    = (div == DIV_W'(CLK_DIV - 1));
  assign mosi    = tx_sr[7] & ~cs_n;
  assign wr_take = (state == S_LOAD) && (phase == P_DATA) && !rd_q;
  assign bad_len = (len == '0) || (len > LEN_W'(MAX_LEN));

  always_comb begin
    next_byte = 8'h00;
    case (phase)
      P_HDR: case (idx[1:0])
        2'd0:    next_byte = {rd_q, 7'(len_q - 1'b1)};
        2'd1:    next_byte = SEL_BYTE;
        2'd2:    next_byte = a_q[15:8];
        default: next_byte = a_q[7:0];
      endcase
      P_DATA:  next_byte = rd_q ? 8'h00 : wr_data;
      default: next_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      phase    <= P_HDR;
      a_q      <= '0;
      rd_q     <= 1'b0;
      len_q    <= '0;
      idx      <= '0;
      poll     <= '0;
      div      <= '0;
      bit_cnt  <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      status   <= ST_OK;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (bad_len) begin
            done   <= 1'b1;
            status <= ST_BADPARAM;
          end else begin
            a_q   <= addr;
            rd_q  <= is_read;
            len_q <= len;
            idx   <= '0;
            poll  <= '0;
            phase <= P_HDR;
            cs_n  <= 1'b0;
            state <= S_LOAD;
          end
        end
        S_LOAD: begin
          tx_sr   <= next_byte;
          bit_cnt <= '0;
          div     <= '0;
          sclk    <= 1'b0;
          state   <= S_BIT;
        end
        default: begin
          div <= tick ? '0 : div + 1'b1;
          if (tick) begin
            if (!sclk) begin
              sclk  <= 1'b1;
              rx_sr <= {rx_sr[6:0], miso};
            end else begin
              sclk <= 1'b0;
              if (bit_cnt != 3'd7) begin
                bit_cnt <= bit_cnt + 1'b1;
                tx_sr   <= {tx_sr[6:0], 1'b0};
              end else begin
                state <= S_LOAD;
                case (phase)
                  P_HDR: begin
                    if (idx != LEN_W'(3)) idx <= idx + 1'b1;
                    else begin
                      idx   <= '0;
                      phase <= rx_sr[0] ? P_DATA : P_WAIT;
                    end
                  end
                  P_WAIT: begin
                    if (rx_sr[0]) phase <= P_DATA;
                    else if (poll == PC_W'(POLL_LIMIT - 1)) begin
                      cs_n   <= 1'b1;
                      done   <= 1'b1;
                      status <= ST_TIMEOUT;
                      state  <= S_IDLE;
                    end else poll <= poll + 1'b1;
                  end
                  default: begin
                    if (rd_q) begin
                      rd_valid <= 1'b1;
                      rd_data  <= rx_sr;
                    end
                    if (idx == len_q - 1'b1) begin
                      cs_n   <= 1'b1;
                      done   <= 1'b1;
                      status <= ST_OK;
                      state  <= S_IDLE;
                    end else idx <= idx + 1'b1;
                  end
                endcase
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tpm_spi_xact_chk.sv
module tpm_spi_xact_chk #(
  parameter int MAX_LEN = 128,
  parameter int LEN_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] len,
  input logic             busy,
  input logic             done,
  input logic [1:0]       status,
  input logic             wr_take,
  input logic             sclk,
  input logic             cs_n
);
  AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n); // R10
  AST_CS_RISE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> done); // R10
  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R11
  AST_BAD_LEN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (len == '0 || len > LEN_W'(MAX_LEN))) |=> (done && status == 2'd1 && cs_n)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R12
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (status != 2'd3)); // R12
  AST_TAKE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) wr_take |-> (busy && !cs_n)); // R8
endmodule

bind tpm_spi_xact tpm_spi_xact_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .len(len), .busy(busy), .done(done),
  .status(status), .wr_take(wr_take), .sclk(sclk), .cs_n(cs_n)
);

// File: tb/tpm_spi_xact_tb_top.sv
`timescale 1ns/1ps
module tpm_spi_xact_tb_top;
  localparam int CLK_DIV = 2;
  logic clk = 0, rst_n = 0, start = 0, is_read = 0, miso = 0;
  logic [15:0] addr = 0;
  logic [7:0] len = 0, wr_data, rd_data;
  logic busy, done, wr_take, rd_valid, sclk, cs_n, mosi;
  logic [1:0] status;

  tpm_spi_xact #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read), .addr(addr), .len(len),
    .busy(busy), .done(done), .status(status), .wr_take(wr_take), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int w_cfg = 0, s_cnt = 0, s_bit = 0, cs_falls = 0, sclk_rises = 0, bad_half = 0;
  int wr_idx = 0, rd_n = 0;
  logic [7:0] s_log [0:255];
  logic [7:0] rd_log [0:255];
  logic [7:0] s_rx = 0, s_tx = 0;
  realtime t_rise = 0;

  function automatic logic [7:0] wmem(int d); return 8'(8'hC3 + d * 13); endfunction
  function automatic logic [7:0] rmem(int d); return 8'(8'h5A ^ (d * 7)); endfunction
  function automatic logic [7:0] resp(int n);
    int p;
    if (n < 3) return 8'h00;
    if (n == 3) return (w_cfg == 0) ? 8'hFF : 8'hFE;
    p = n - 4;
    if (w_cfg > 0 && p < w_cfg) return (p >= w_cfg - 1) ? 8'h01 : 8'hFE;
    return rmem(n - 4 - w_cfg);
  endfunction

  assign wr_data = wmem(wr_idx);
  always @(posedge clk) if (wr_take) wr_idx <= wr_idx + 1;
  always @(posedge clk) if (rd_valid) begin rd_log[rd_n] <= rd_data; rd_n <= rd_n + 1; end

  always @(negedge cs_n) begin
    cs_falls++; s_bit = 0; s_tx = resp(s_cnt); miso = s_tx[7];
  end
  always @(posedge sclk) if (!cs_n) begin
    sclk_rises++; t_rise = $realtime;
    s_rx = {s_rx[6:0], mosi}; s_bit++;
    if (s_bit == 8) begin
      s_log[s_cnt] = s_rx; s_cnt++; s_bit = 0; s_tx = resp(s_cnt);
    end
  end
  always @(negedge sclk) if (!cs_n) begin
    if ($realtime - t_rise != CLK_DIV * 10) bad_half++;
    miso = s_tx[7 - s_bit];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic run_access(input bit rd, input int ln, input logic [15:0] ad, input int w,
                            output logic [1:0] st);
    int cyc = 0;
    @(negedge clk);
    w_cfg = w; s_cnt = 0; cs_falls = 0; sclk_rises = 0; bad_half = 0; wr_idx = 0; rd_n = 0;
    start = 1; is_read = rd; len = 8'(ln); addr = ad;
    @(negedge clk); start = 0;
    while (!done && cyc < 30000) begin @(negedge clk); cyc++; end
    chk(done, "R12 done seen", done, 1);
    st = status;
    chk(cs_n == 1, "R10 cs_n high at done", cs_n, 1);
    @(negedge clk);
    chk(!done, "R12 done single cycle", done, 0);
  endtask

  task automatic check_ok(input bit rd, input int ln, input logic [15:0] ad, input int w);
    logic [1:0] st;
    int polls;
    bit ok;
    run_access(rd, ln, ad, w, st);
    polls = w;
    chk(st == 2'd0, "R12 success status", st, 0);
    chk(cs_falls == 1, "R10 single cs_n assertion", cs_falls, 1);
    chk(s_cnt == 4 + polls + ln, "R5 R6 byte count on bus", s_cnt, 4 + polls + ln);
    chk(sclk_rises == 8 * s_cnt, "R11 eight clocks per byte", sclk_rises, 8 * s_cnt);
    chk(bad_half == 0, "R11 SCLK half period", bad_half, 0);
    chk(s_log[0] == {rd, 7'(ln - 1)}, "R1 header byte 0", s_log[0], {rd, 7'(ln - 1)});
    chk(s_log[1] == 8'hD4, "R3 header byte 1", s_log[1], 8'hD4);
    chk(s_log[2] == ad[15:8], "R4 address high", s_log[2], ad[15:8]);
    chk(s_log[3] == ad[7:0], "R4 address low", s_log[3], ad[7:0]);
    ok = 1;
    for (int p = 0; p < polls; p++) if (s_log[4 + p] != 8'h00) ok = 0;
    chk(ok, "R6 filler bytes are zero", ok, 1);
    if (rd) begin
      chk(rd_n == ln, "R9 read byte count", rd_n, ln);
      chk(wr_idx == 0, "R9 no write take on read", wr_idx, 0);
      ok = 1;
      for (int d = 0; d < ln; d++) if (rd_log[d] != rmem(d)) ok = 0;
      chk(ok, "R9 read data", ok, 1);
    end else begin
      chk(wr_idx == ln, "R8 write take count", wr_idx, ln);
      chk(rd_n == 0, "R8 no read strobe on write", rd_n, 0);
      ok = 1;
      for (int d = 0; d < ln; d++) if (s_log[4 + polls + d] != wmem(d)) ok = 0;
      chk(ok, "R8 write data on MOSI", ok, 1);
    end
  endtask

  task automatic t_reset;
    chk(cs_n == 1 && sclk == 0, "R11 idle bus after reset", {cs_n, sclk}, 2);
    chk(!busy && !done, "R12 idle after reset", {busy, done}, 0);
  endtask

  task automatic t_write_direct; check_ok(0, 4, 16'h0F18, 0); endtask
  task automatic t_read_polled;  check_ok(1, 2, 16'hA5C3, 3); endtask
  task automatic t_read_single;  check_ok(1, 1, 16'h0000, 1); endtask
  task automatic t_read_max;     check_ok(1, 128, 16'hFFFF, 0); endtask
  task automatic t_poll_edge;    check_ok(0, 1, 16'h1234, 50); endtask

  task automatic t_timeout;
    logic [1:0] st;
    run_access(0, 3, 16'h0024, 51, st);
    chk(st == 2'd2, "R7 timeout status", st, 2);
    chk(s_cnt == 54, "R7 fifty filler bytes then stop", s_cnt, 54);
    chk(wr_idx == 0, "R7 no data byte taken", wr_idx, 0);
    chk(cs_falls == 1, "R10 cs released after timeout", cs_falls, 1);
  endtask

  task automatic t_reject(input int ln);
    logic [1:0] st;
    run_access(0, ln, 16'h0F00, 0, st);
    chk(st == 2'd1, "R2 invalid parameter status", st, 1);
    chk(cs_falls == 0 && sclk_rises == 0, "R2 no bus activity", cs_falls + sclk_rises, 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_direct();
    t_read_polled();
    t_read_single();
    t_read_max();
    t_poll_edge();
    t_timeout();
    t_reject(0);
    t_reject(129);
    t_reject(255);
    check_ok(0, 2, 16'hBEEF, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule